// File: doc/BRIEF.md
# Wildcard Chunk Class Classifier

This block assigns a class number to every four-byte chunk of an input stream. A table of up to 32 patterns is loaded through a write port. Each pattern has four positions, and each position is either a literal byte or a wildcard that accepts any byte. Each pattern also carries the class number it stands for. Patterns with trailing wildcards, patterns with leading wildcards, and fully literal patterns built from combining the two can all sit in the same table.

When a chunk matches several patterns, the pattern with the most literal positions supplies the class. Among equally specific patterns, the lowest table slot wins. A chunk that matches nothing receives a single fixed fallback class. Results come out a fixed two cycles after the chunk, so a downstream state-transition stage can be fed one chunk per clock.

Top module: `chunk_classifier`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0. Reset empties the table, so after reset every chunk is given the fallback class `DFLT_CLASS` (31 by default).
- R2: `out_valid` is high exactly two rising edges after the edge that samples `in_valid` high, and at no other time.
- R3: Position p of a chunk is `in_chunk[8p+7:8p]`, and position 0 is the earliest symbol. A pattern position whose `wr_lit[p]` bit is 1 matches only when that chunk byte equals `wr_sym[8p+7:8p]`. A position whose bit is 0 matches any byte.
- R4: An entry whose four literal bits are all 0 never supplies a class.
- R5: A chunk that matches no active entry is given `DFLT_CLASS`.
- R6: When several entries match, the class comes from the entry with the most literal positions. A fully literal entry therefore wins over a matching entry with leading wildcards and over a matching entry with trailing wildcards.
- R7: When the most specific matching entries have the same number of literal positions, the entry in the lowest table slot supplies the class.
- R8: A write at one edge affects chunks sampled at later edges only. A chunk sampled at the same edge as a write is classified against the contents from before that write.
- R9: Writing a slot again replaces its pattern and class completely.
- R10: Chunks presented on consecutive cycles are each classified correctly, in order, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one table slot |
| wr_idx | input | 5 | Slot to write |
| wr_lit | input | 4 | Literal flag per position (1 = literal, 0 = wildcard) |
| wr_sym | input | 32 | Literal bytes, position p in bits [8p+7:8p] |
| wr_cls | input | 5 | Class number held by the slot |
| in_valid | input | 1 | Chunk present |
| in_chunk | input | 32 | Chunk, position p in bits [8p+7:8p] |
| out_valid | output | 1 | Class result present |
| out_class | output | 5 | Class of the chunk sampled two edges earlier |

## Verification
The bench builds the block with its default parameters: 32 slots, four byte-wide positions, 5-bit classes and fallback class 31. Four positions make every specificity level from one to four literals reachable. A parent/child pattern set (two leading bytes fixed, two trailing bytes fixed, and all four fixed) exercises the override of both parents by their intersection. Random chunks drawn from a four-letter alphabet make overlapping and tied matches common, and each is scored against a priority model built from the requirements.

// File: rtl/cc_pkg.sv
package cc_pkg;
    localparam int CC_ENTRIES = 32;
    localparam int CC_POS_N   = 4;
    localparam int CC_SYM_W   = 8;
    localparam int CC_CLASS_W = 5;
endpackage

// File: rtl/cc_entry_match.sv
module cc_entry_match #(
    parameter int POS_N  = cc_pkg::CC_POS_N,
    parameter int SYM_W  = cc_pkg::CC_SYM_W,
    parameter int SPEC_W = $clog2(POS_N + 1)
) (
    input  logic [POS_N-1:0]       lit,
    input  logic [POS_N*SYM_W-1:0] sym,
    input  logic [POS_N*SYM_W-1:0] chunk,
    output logic                   hit,
    output logic [SPEC_W-1:0]      spec
);
    logic [POS_N-1:0] pos_ok;

    for (genvar p = 0; p < POS_N; p++) begin : g_pos
        assign pos_ok[p] = !lit[p] ||
                           (sym[p*SYM_W +: SYM_W] == chunk[p*SYM_W +: SYM_W]);
    end

    // an all-wildcard slot is inactive: the fallback class covers that case
    assign hit  = (|lit) && (&pos_ok);
    assign spec = SPEC_W'($countones(lit));
endmodule

// File: rtl/cc_level_pick.sv
module cc_level_pick #(
    parameter int ENTRIES = cc_pkg::CC_ENTRIES,
    parameter int SPEC_W  = 3,
    parameter int CLASS_W = cc_pkg::CC_CLASS_W,
    parameter int LEVEL   = 1
) (
    input  logic [ENTRIES-1:0]              hit,
    input  logic [ENTRIES-1:0][SPEC_W-1:0]  spec,
    input  logic [ENTRIES-1:0][CLASS_W-1:0] cls,
    output logic                            found,
    output logic [CLASS_W-1:0]              cls_out
);
    // scan downward so the lowest matching slot is the last one written
    always_comb begin
        found   = 1'b0;
        cls_out = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit[i] && spec[i] == SPEC_W'(LEVEL)) begin
                found   = 1'b1;
                cls_out = cls[i];
            end
        end
    end
endmodule

// File: rtl/chunk_classifier.sv
module chunk_classifier #(
    parameter int ENTRIES = cc_pkg::CC_ENTRIES,
    parameter int POS_N   = cc_pkg::CC_POS_N,
    parameter int SYM_W   = cc_pkg::CC_SYM_W,
    parameter int CLASS_W = cc_pkg::CC_CLASS_W,
    parameter logic [CLASS_W-1:0] DFLT_CLASS = '1,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int CHUNK_W = POS_N * SYM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [POS_N-1:0]   wr_lit,
    input  logic [CHUNK_W-1:0] wr_sym,
    input  logic [CLASS_W-1:0] wr_cls,
    input  logic               in_valid,
    input  logic [CHUNK_W-1:0] in_chunk,
    output logic               out_valid,
    output logic [CLASS_W-1:0] out_class
);
    localparam int SPEC_W = $clog2(POS_N + 1);

    typedef struct packed {
        logic [POS_N-1:0]   lit;
        logic [CHUNK_W-1:0] sym;
        logic [CLASS_W-1:0] cls;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0]            tbl;
        logic                            s1_valid;
        logic [POS_N-1:0]                lvl_found;
        logic [POS_N-1:0][CLASS_W-1:0]   lvl_cls;
        logic                            out_valid;
        logic [CLASS_W-1:0]              out_cls;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0]              hit;
    logic [ENTRIES-1:0][SPEC_W-1:0]  spec;
    logic [ENTRIES-1:0][CLASS_W-1:0] cls_vec;
    logic [POS_N-1:0]                found_w;
    logic [POS_N-1:0][CLASS_W-1:0]   lvl_cls_w;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        assign cls_vec[i] = st_q.tbl[i].cls;

        cc_entry_match #(.POS_N(POS_N), .SYM_W(SYM_W), .SPEC_W(SPEC_W)) u_match (
            .lit   (st_q.tbl[i].lit),
            .sym   (st_q.tbl[i].sym),
            .chunk (in_chunk),
            .hit   (hit[i]),
            .spec  (spec[i])
        );

        // R4: inactive slot never reports a hit
        a_r4_empty_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |-> (spec[i] != '0));
    end

    for (genvar l = 0; l < POS_N; l++) begin : g_lvl
        cc_level_pick #(.ENTRIES(ENTRIES), .SPEC_W(SPEC_W), .CLASS_W(CLASS_W),
                        .LEVEL(l + 1)) u_pick (
            .hit     (hit),
            .spec    (spec),
            .cls     (cls_vec),
            .found   (found_w[l]),
            .cls_out (lvl_cls_w[l])
        );
    end

    always_comb begin
        st_d = st_q;
        if (wr_en && (int'(wr_idx) < ENTRIES)) begin
            st_d.tbl[wr_idx].lit = wr_lit;
            st_d.tbl[wr_idx].sym = wr_sym;
            st_d.tbl[wr_idx].cls = wr_cls;
        end
        st_d.s1_valid  = in_valid;
        st_d.lvl_found = found_w;
        st_d.lvl_cls   = lvl_cls_w;
        st_d.out_valid = st_q.s1_valid;
        st_d.out_cls   = DFLT_CLASS;
        for (int l = 0; l < POS_N; l++) begin
            if (st_q.lvl_found[l]) begin
                st_d.out_cls = st_q.lvl_cls[l];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_valid;
    assign out_class = st_q.out_cls;

    // R1: no result while held in reset
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R2: fixed two-edge latency, no spurious results
    a_r2_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);
    a_r2_no_spur: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R5: nothing found at any level gives the fallback class
    a_r5_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_valid && st_q.lvl_found == '0) |=> (out_class == DFLT_CLASS));

    // R6: a fully literal match overrides every lower level
    a_r6_top_level_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_valid && st_q.lvl_found[POS_N-1])
        |=> (out_class == $past(st_q.lvl_cls[POS_N-1])));
endmodule

// File: tb/sim_chunk_classifier.sv
module sim_chunk_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [3:0]  wr_lit = '0;
    logic [31:0] wr_sym = '0;
    logic [4:0]  wr_cls = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_chunk = '0;
    logic        out_valid;
    logic [4:0]  out_class;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [3:0]  m_lit [32];
    logic [31:0] m_sym [32];
    logic [4:0]  m_cls [32];

    int    q_cls [$];
    int    q_due [$];
    string q_tag [$];

    localparam logic [7:0] SA = 8'h41, SB = 8'h42, SD = 8'h44, SQ = 8'h51;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    chunk_classifier u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_lit(wr_lit), .wr_sym(wr_sym), .wr_cls(wr_cls),
        .in_valid(in_valid), .in_chunk(in_chunk),
        .out_valid(out_valid), .out_class(out_class)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] w4(input logic [7:0] p0, p1, p2, p3);
        return {p3, p2, p1, p0};
    endfunction

    function automatic int model(input logic [31:0] ch);
        int best = 31;
        int best_spec = 0;
        for (int i = 0; i < 32; i++) begin
            int s = $countones(m_lit[i]);
            bit ok = 1'b1;
            for (int p = 0; p < 4; p++)
                if (m_lit[i][p] && m_sym[i][p*8 +: 8] != ch[p*8 +: 8]) ok = 1'b0;
            if (s > 0 && ok && s > best_spec) begin
                best = m_cls[i];
                best_spec = s;
            end
        end
        return best;
    endfunction

    task automatic model_wr(input int idx, input logic [3:0] lit, input logic [31:0] sym,
                            input logic [4:0] cls);
        m_lit[idx] = lit; m_sym[idx] = sym; m_cls[idx] = cls;
    endtask

    task automatic put_write(input int idx, input logic [3:0] lit, input logic [31:0] sym,
                             input logic [4:0] cls);
        wr_en = 1'b1; wr_idx = 5'(idx); wr_lit = lit; wr_sym = sym; wr_cls = cls;
        model_wr(idx, lit, sym, cls);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push_exp(input logic [31:0] ch, input string tag);
        q_cls.push_back(model(ch));
        q_due.push_back(cyc + 2);
        q_tag.push_back(tag);
    endtask

    task automatic put_chunk(input logic [31:0] ch, input string tag);
        push_exp(ch, tag);
        in_valid = 1'b1; in_chunk = ch;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // R8: write and chunk at the same edge, chunk sees old contents
    task automatic put_both(input int idx, input logic [3:0] lit, input logic [31:0] sym,
                            input logic [4:0] cls, input logic [31:0] ch, input string tag);
        push_exp(ch, tag);
        wr_en = 1'b1; wr_idx = 5'(idx); wr_lit = lit; wr_sym = sym; wr_cls = cls;
        in_valid = 1'b1; in_chunk = ch;
        model_wr(idx, lit, sym, cls);
        @(negedge clk);
        wr_en = 1'b0; in_valid = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        int    e_cls;
        int    e_due;
        string e_tag;
        if (rst_n && out_valid) begin
            if (q_cls.size() == 0) begin
                chk(1'b0, "R2 unexpected out_valid", 1, 0);
            end else begin
                e_cls = q_cls.pop_front();
                e_due = q_due.pop_front();
                e_tag = q_tag.pop_front();
                chk(int'(out_class) == e_cls, e_tag, int'(out_class), e_cls);
                chk(cyc == e_due, "R2 latency", cyc, e_due);
            end
        end
    end

    task automatic finish_up;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        finish_up();
    end

    initial begin
        for (int i = 0; i < 32; i++) model_wr(i, 4'b0, 32'h0, 5'd0);
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        put_chunk(w4(SD, SB, SA, SB), "R1 empty table fallback");
        put_chunk(w4(SQ, SQ, SQ, SQ), "R5 no match");

        put_write(3, 4'b0011, w4(SD, SB, 8'h00, 8'h00), 5'd7);
        put_write(5, 4'b1100, w4(8'h00, 8'h00, SA, SB), 5'd12);
        put_write(9, 4'b1111, w4(SD, SB, SA, SB), 5'd20);
        put_write(2, 4'b0101, w4(SD, 8'h00, SA, 8'h00), 5'd9);
        put_write(1, 4'b0001, w4(SD, 8'h00, 8'h00, 8'h00), 5'd3);
        put_write(0, 4'b0000, w4(SQ, SQ, SQ, SQ), 5'd30);
        @(negedge clk);

        put_chunk(w4(SD, SB, SQ, SQ), "R3 trailing wildcards");
        put_chunk(w4(SQ, SQ, SA, SB), "R3 leading wildcards");
        put_chunk(w4(SD, SB, SA, SB), "R6 intersection wins");
        put_chunk(w4(SD, SQ, SQ, SQ), "R6 single literal over fallback");
        put_chunk(w4(SD, SB, SA, SQ), "R7 tie lowest slot");
        put_chunk(w4(SQ, SQ, SQ, SQ), "R4 all-wildcard slot inactive");
        put_chunk(w4(SB, SD, SA, SB), "R3 byte order matters");
        @(negedge clk);

        put_write(9, 4'b0000, w4(SD, SB, SA, SB), 5'd20);
        put_chunk(w4(SD, SB, SA, SB), "R9 rewrite removes slot");

        put_both(9, 4'b1111, w4(SD, SB, SA, SB), 5'd21, w4(SD, SB, SA, SB), "R8 same-edge old contents");
        put_chunk(w4(SD, SB, SA, SB), "R8 write visible next edge");
        put_write(9, 4'b1111, w4(SD, SB, SA, SB), 5'd22);
        put_chunk(w4(SD, SB, SA, SB), "R9 new class replaces old");

        for (int n = 0; n < 300; n++) begin
            logic [7:0] b [4];
            for (int p = 0; p < 4; p++) begin
                case ($urandom % 4)
                    0: b[p] = SA;
                    1: b[p] = SB;
                    2: b[p] = SD;
                    default: b[p] = SQ;
                endcase
            end
            if (($urandom % 4) == 0) @(negedge clk);
            put_chunk(w4(b[0], b[1], b[2], b[3]), "R10 streamed chunk");
        end

        repeat (5) @(negedge clk);
        chk(q_cls.size() == 0, "R2 results outstanding", q_cls.size(), 0);
        finish_up();
    end
endmodule